// File: doc/BRIEF.md
# Link Interface Wake Sequencer

This block sits on the physical-layer side of a parallel interface to a link controller. It brings that interface back into service after a reset or a disabled period. The link controller asks for service by raising its power-status line. The block first checks that the interface has been off for a minimum number of reference-clock cycles. It then restarts the interface clock and steps the 2-bit control bus and the data bus through a start-up pattern that is exact to the cycle. The buses are held low for seven cycles. Next comes a receive indication with the data bus all ones, and after that the interface goes idle. Only in the idle state are the link controller's requests accepted.

The sequence runs when the mode pin is high. It runs the same way whether the interface was only reset or fully disabled. If power-status drops at any point, the block returns to its off state, clears its progress and begins timing the off period again. A contention detector watches the link side's output enable. It flags any cycle in which the link drives the shared buses against the block, with one exception: the link may drive zeros during wake cycles 1 to 6.

Top module: `lnk_wake_seq`

## Requirements
- R1: After reset or an abort, no wake begins until the block has spent at least MIN_OFF clock cycles in the off state. A power-status high seen earlier is held off until that count is reached.
- R2: The block starts a wake when power-status is high, mode is high and the off time has been met. `clk_run_o` rises on the next clock edge and stays high until the block returns to the off state.
- R3: In wake cycles 1 to 7, both output enables are high, `ctl_o` is 2'b00 and `d_o` is all zeros.
- R4: From wake cycle 8 for RX_LEN cycles (RX_LEN at least 1), `ctl_o` carries the receive code 2'b10 and `d_o` is all ones.
- R5: After the receive indication, `ctl_o` carries the idle code 2'b00, `d_o` is zero and `ready_o` is high.
- R6: `req_acc_o` equals `lreq_i` while `ready_o` is high and is 0 at all other times, so requests made before initialization completes are ignored.
- R7: While `mode_i` is low, the block stays in the off state, whatever power-status does.
- R8: When power-status is low on a clock edge outside the off state, the block returns to the off state on that edge. In the off state, `clk_run_o`, `ready_o` and both enables are low, and the off-time count starts again from zero.
- R9: `contend_o` is high for one cycle after any edge at which `link_oe_i` is high while the block's enables are high. The exception is an edge in wake cycles 1 to 6 at which the link drives all zeros on both buses.
- R10: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | Mode pin; high selects this wake sequence |
| lps_i | input | 1 | Link power-status |
| lreq_i | input | 1 | Link request line |
| link_oe_i | input | 1 | Link side is driving the shared buses |
| link_ctl_i | input | 2 | Value the link drives on the control bus |
| link_d_i | input | DW | Value the link drives on the data bus |
| ctl_o | output | 2 | Control bus value |
| ctl_oe_o | output | 1 | Control bus output enable |
| d_o | output | DW | Data bus value |
| d_oe_o | output | 1 | Data bus output enable |
| clk_run_o | output | 1 | Interface clock run enable |
| ready_o | output | 1 | Initialization complete |
| req_acc_o | output | 1 | Request accepted this cycle |
| contend_o | output | 1 | Bus contention seen on the previous edge |

## Verification
Two pairs of functions can land on the same cycle. First, an abort can coincide with a step of the wake pattern. The bench holds `lreq_i` high while dropping power-status on the same edge that would move the receive indication into idle, so `ready_o` must never rise and `req_acc_o` must stay low. Second, contention detection can coincide with the end of the window in which the link may drive zeros. The link drives zeros on cycle 6 and again on cycle 7: the first must be accepted silently and the second must be flagged. A behavioural per-cycle model in the bench judges every output on every clock, including these cycles.

// File: rtl/lnk_wake_pkg.sv
`timescale 1ns/100ps
package lnk_wake_pkg;

  typedef enum logic [1:0] {
    PH_OFF  = 2'd0,
    PH_HOLD = 2'd1,
    PH_RECV = 2'd2,
    PH_IDLE = 2'd3
  } phase_e;

  localparam logic [1:0] CTL_IDLE = 2'b00;
  localparam logic [1:0] CTL_RECV = 2'b10;

  // cycles with both buses held low after restart
  localparam int unsigned HOLD_CYC = 7;
  // last wake cycle on which the link may drive zeros
  localparam int unsigned LINK_WIN = 6;

  function automatic logic [1:0] ctl_for(phase_e p);
    return (p == PH_RECV) ? CTL_RECV : CTL_IDLE;
  endfunction

  function automatic logic in_link_window(phase_e p, int unsigned cyc);
    return (p == PH_HOLD) && (cyc >= 1) && (cyc <= LINK_WIN);
  endfunction

  function automatic int unsigned recv_end(int unsigned rx_len);
    return HOLD_CYC + rx_len;
  endfunction

endpackage

// File: rtl/lnk_off_timer.sv
`timescale 1ns/100ps
module lnk_off_timer #(
  parameter int unsigned MIN_OFF = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_off,
  output logic off_done
);
  localparam int unsigned OW = $clog2(MIN_OFF + 2);
  localparam logic [OW-1:0] LIM = OW'(MIN_OFF);

  logic [OW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (!in_off)     cnt_q <= '0;
    else if (cnt_q < LIM) cnt_q <= cnt_q + OW'(1);
  end

  assign off_done = (cnt_q >= LIM);
endmodule

// File: rtl/lnk_wake_fsm.sv
`timescale 1ns/100ps
module lnk_wake_fsm
  import lnk_wake_pkg::*;
#(
  parameter int unsigned RX_LEN = 2,
  parameter int unsigned CW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          lps_i,
  output phase_e        phase_o,
  output logic [CW-1:0] cyc_o
);
  localparam logic [CW-1:0] HOLD_END = CW'(HOLD_CYC);
  localparam logic [CW-1:0] RECV_END = CW'(recv_end(RX_LEN));

  phase_e        ph_q, ph_d;
  logic [CW-1:0] cyc_q, cyc_d;

  always_comb begin
    ph_d  = ph_q;
    cyc_d = cyc_q;
    unique case (ph_q)
      PH_OFF: begin
        if (go) begin
          ph_d  = PH_HOLD;
          cyc_d = CW'(1);
        end
      end
      PH_HOLD: begin
        if (!lps_i) begin
          ph_d  = PH_OFF;
          cyc_d = '0;
        end else begin
          cyc_d = cyc_q + CW'(1);
          if (cyc_q == HOLD_END) ph_d = PH_RECV;
        end
      end
      PH_RECV: begin
        if (!lps_i) begin
          ph_d  = PH_OFF;
          cyc_d = '0;
        end else if (cyc_q == RECV_END) begin
          ph_d = PH_IDLE;
        end else begin
          cyc_d = cyc_q + CW'(1);
        end
      end
      PH_IDLE: begin
        if (!lps_i) begin
          ph_d  = PH_OFF;
          cyc_d = '0;
        end
      end
      default: begin
        ph_d  = PH_OFF;
        cyc_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_OFF;
      cyc_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cyc_q <= cyc_d;
    end
  end

  assign phase_o = ph_q;
  assign cyc_o   = cyc_q;
endmodule

// File: rtl/lnk_bus_guard.sv
`timescale 1ns/100ps
module lnk_bus_guard #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          win,
  input  logic          bus_oe,
  input  logic          link_oe_i,
  input  logic [1:0]    link_ctl_i,
  input  logic [DW-1:0] link_d_i,
  output logic          contend_o
);
  logic link_zero;
  logic clash;

  assign link_zero = (link_ctl_i == 2'b00) && (link_d_i == '0);
  assign clash     = link_oe_i && bus_oe && !(win && link_zero);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) contend_o <= 1'b0;
    else        contend_o <= clash;
  end
endmodule

// File: rtl/lnk_wake_seq.sv
`timescale 1ns/100ps
module lnk_wake_seq
  import lnk_wake_pkg::*;
#(
  parameter int unsigned MIN_OFF = 16,
  parameter int unsigned RX_LEN  = 2,
  parameter int unsigned DW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_i,
  input  logic          lps_i,
  input  logic          lreq_i,
  input  logic          link_oe_i,
  input  logic [1:0]    link_ctl_i,
  input  logic [DW-1:0] link_d_i,
  output logic [1:0]    ctl_o,
  output logic          ctl_oe_o,
  output logic [DW-1:0] d_o,
  output logic          d_oe_o,
  output logic          clk_run_o,
  output logic          ready_o,
  output logic          req_acc_o,
  output logic          contend_o
);
  localparam int unsigned CW = $clog2(recv_end(RX_LEN) + 2);

  phase_e        phase_w;
  logic [CW-1:0] cyc_w;
  logic          off_done_w;
  logic          start_w;
  logic          in_off_w;
  logic          in_hold_w;
  logic          in_recv_w;
  logic          win_w;

  assign in_off_w  = (phase_w == PH_OFF);
  assign in_hold_w = (phase_w == PH_HOLD);
  assign in_recv_w = (phase_w == PH_RECV);
  assign start_w   = in_off_w && off_done_w && lps_i && mode_i;
  assign win_w     = in_link_window(phase_w, 32'(cyc_w));

  lnk_off_timer #(.MIN_OFF(MIN_OFF)) u_off (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_off   (in_off_w),
    .off_done (off_done_w)
  );

  lnk_wake_fsm #(.RX_LEN(RX_LEN), .CW(CW)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (start_w),
    .lps_i   (lps_i),
    .phase_o (phase_w),
    .cyc_o   (cyc_w)
  );

  lnk_bus_guard #(.DW(DW)) u_guard (
    .clk        (clk),
    .rst_n      (rst_n),
    .win        (win_w),
    .bus_oe     (ctl_oe_o),
    .link_oe_i  (link_oe_i),
    .link_ctl_i (link_ctl_i),
    .link_d_i   (link_d_i),
    .contend_o  (contend_o)
  );

  assign clk_run_o = !in_off_w;
  assign ctl_oe_o  = !in_off_w;
  assign d_oe_o    = !in_off_w;
  assign ctl_o     = ctl_for(phase_w);
  assign d_o       = {DW{in_recv_w}};
  assign ready_o   = (phase_w == PH_IDLE);
  assign req_acc_o = ready_o && lreq_i;
endmodule

// File: rtl/lnk_wake_chk.sv
`timescale 1ns/100ps
module lnk_wake_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_i,
  input logic          lps_i,
  input logic          link_oe_i,
  input logic          start_w,
  input logic          off_done_w,
  input logic          in_hold_w,
  input logic          in_recv_w,
  input logic          ctl_oe_o,
  input logic          clk_run_o,
  input logic [1:0]    ctl_o,
  input logic [DW-1:0] d_o,
  input logic          ready_o,
  input logic          req_acc_o,
  input logic          contend_o
);
  assert_wait_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_run_o) |-> $past(off_done_w) && $past(lps_i));

  assert_run_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |=> clk_run_o);

  assert_hold_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_hold_w |-> (ctl_o == 2'b00) && (d_o == '0) && ctl_oe_o);

  assert_recv_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_recv_w |-> (ctl_o == 2'b10) && (d_o == '1));

  assert_ready_after_recv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> $past(in_recv_w) && (ctl_o == 2'b00));

  assert_req_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_acc_o |-> ready_o);

  assert_mode_low_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_i && !clk_run_o |=> !clk_run_o);

  assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clk_run_o && !lps_i |=> !clk_run_o && !ready_o);

  assert_no_clash_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(link_oe_i && ctl_oe_o) |=> !contend_o);
endmodule

bind lnk_wake_seq lnk_wake_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_i     (mode_i),
  .lps_i      (lps_i),
  .link_oe_i  (link_oe_i),
  .start_w    (start_w),
  .off_done_w (off_done_w),
  .in_hold_w  (in_hold_w),
  .in_recv_w  (in_recv_w),
  .ctl_oe_o   (ctl_oe_o),
  .clk_run_o  (clk_run_o),
  .ctl_o      (ctl_o),
  .d_o        (d_o),
  .ready_o    (ready_o),
  .req_acc_o  (req_acc_o),
  .contend_o  (contend_o)
);

// File: tb/lnk_wake_seq_bench.sv
`timescale 1ns/100ps
module lnk_wake_seq_bench;
  localparam int MIN_OFF = 16;
  localparam int RX_LEN  = 2;
  localparam int DW      = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_i = 1'b0;
  logic          lps_i = 1'b0;
  logic          lreq_i = 1'b0;
  logic          link_oe_i = 1'b0;
  logic [1:0]    link_ctl_i = 2'b00;
  logic [DW-1:0] link_d_i = '0;
  logic [1:0]    ctl_o;
  logic          ctl_oe_o;
  logic [DW-1:0] d_o;
  logic          d_oe_o;
  logic          clk_run_o;
  logic          ready_o;
  logic          req_acc_o;
  logic          contend_o;

  int total = 0;
  int bad = 0;
  int cont_seen = 0;
  int acc_seen = 0;
  bit auto_req = 1'b1;

  // reference model state: m_ph 0 = off, otherwise m_c counts wake cycles
  int m_ph = 0;
  int m_c = 0;
  int m_off = 0;
  int m_cont = 0;

  always #2.5 clk = ~clk;

  lnk_wake_seq #(.MIN_OFF(MIN_OFF), .RX_LEN(RX_LEN), .DW(DW)) u_lnk_wake_seq (
    .clk, .rst_n, .mode_i, .lps_i, .lreq_i, .link_oe_i, .link_ctl_i, .link_d_i,
    .ctl_o, .ctl_oe_o, .d_o, .d_oe_o, .clk_run_o, .ready_o, .req_acc_o, .contend_o
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_c = 0; m_off = 0; m_cont = 0;
    end else begin
      m_cont = (link_oe_i && m_ph != 0 &&
                !(m_c >= 1 && m_c <= 6 && link_ctl_i == 2'b00 && link_d_i == '0)) ? 1 : 0;
      if (m_ph == 0) begin
        if (m_off >= MIN_OFF && lps_i && mode_i) begin
          m_ph = 1; m_c = 1;
        end
        if (m_off < MIN_OFF) m_off++;
      end else begin
        m_off = 0;
        if (!lps_i) begin
          m_ph = 0; m_c = 0;
        end else if (m_c < 8 + RX_LEN) begin
          m_c++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // advance one clock, then compare every output with the model
  task automatic tick();
    int e_ctl, e_d, e_rdy, e_on;
    string tag;
    @(posedge clk);
    #2;
    e_on  = (m_ph != 0) ? 1 : 0;
    e_rdy = (m_ph != 0 && m_c > 7 + RX_LEN) ? 1 : 0;
    e_ctl = (m_ph != 0 && m_c >= 8 && m_c <= 7 + RX_LEN) ? 2 : 0;
    e_d   = (e_ctl == 2) ? 255 : 0;
    tag   = (e_ctl == 2) ? "R4" : (e_rdy == 1) ? "R5" : (e_on == 1) ? "R3" : "R8";
    chk(int'(clk_run_o) == e_on, "R2 clk_run", int'(clk_run_o), e_on);
    chk(int'(ctl_oe_o) == e_on && int'(d_oe_o) == e_on, {tag, " enables"},
        int'({ctl_oe_o, d_oe_o}), e_on * 3);
    chk(int'(ctl_o) == e_ctl, {tag, " ctl"}, int'(ctl_o), e_ctl);
    chk(int'(d_o) == e_d, {tag, " data"}, int'(d_o), e_d);
    chk(int'(ready_o) == e_rdy, {tag, " ready"}, int'(ready_o), e_rdy);
    chk(int'(req_acc_o) == (e_rdy & int'(lreq_i)), "R6 req_acc", int'(req_acc_o),
        e_rdy & int'(lreq_i));
    chk(int'(contend_o) == m_cont, "R9 contend", int'(contend_o), m_cont);
    if (contend_o) cont_seen++;
    if (req_acc_o) acc_seen++;
    if (auto_req) lreq_i = ~lreq_i;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wait_run();
    for (int i = 0; i < 200 && !clk_run_o; i++) tick();
  endtask

  initial begin
    // R10: reset holds every output low
    ticks(3);
    chk({ctl_o, ctl_oe_o, d_o, d_oe_o, clk_run_o, ready_o, req_acc_o, contend_o} == '0,
        "R10 reset outputs", int'(clk_run_o), 0);
    rst_n = 1'b1;
    mode_i = 1'b1;
    lps_i = 1'b1;
    // R1: power-status high early does not start the wake
    ticks(5);
    chk(clk_run_o == 1'b0, "R1 early start", int'(clk_run_o), 0);
    wait_run();
    chk(clk_run_o == 1'b1, "R2 wake started", int'(clk_run_o), 1);
    // link drives zeros on cycle 3 (allowed), nonzero on cycle 4
    ticks(2);
    link_oe_i = 1'b1;
    tick();
    link_ctl_i = 2'b01;
    tick();
    link_oe_i = 1'b0; link_ctl_i = 2'b00;
    // zeros on cycle 6 allowed, on cycle 7 flagged
    tick();
    link_oe_i = 1'b1;
    ticks(2);
    link_oe_i = 1'b0;
    ticks(8);
    chk(ready_o == 1'b1, "R5 ready reached", int'(ready_o), 1);
    // link drives while idle: clash
    link_oe_i = 1'b1;
    tick();
    link_oe_i = 1'b0;
    ticks(6);
    chk(cont_seen > 0, "R9 contention seen", cont_seen, 1);
    chk(acc_seen > 0, "R6 request accepted", acc_seen, 1);

    // R8: drop in idle, then power-status back at once must wait off time
    lps_i = 1'b0;
    tick();
    chk(clk_run_o == 1'b0 && ready_o == 1'b0, "R8 abort from idle", int'(clk_run_o), 0);
    lps_i = 1'b1;
    ticks(MIN_OFF - 2);
    chk(clk_run_o == 1'b0, "R8 off timer restarted", int'(clk_run_o), 0);
    wait_run();
    // abort during hold
    ticks(3);
    lps_i = 1'b0;
    tick();
    chk(clk_run_o == 1'b0, "R8 abort in hold", int'(clk_run_o), 0);

    // R7: mode low keeps the block off
    mode_i = 1'b0;
    lps_i = 1'b1;
    ticks(MIN_OFF + 20);
    chk(clk_run_o == 1'b0, "R7 mode low", int'(clk_run_o), 0);
    mode_i = 1'b1;
    wait_run();
    // abort on the edge that would enter idle, request held high
    auto_req = 1'b0;
    lreq_i = 1'b1;
    ticks(6 + RX_LEN);
    lps_i = 1'b0;
    tick();
    chk(ready_o == 1'b0 && req_acc_o == 1'b0, "R6 no accept on abort edge",
        int'(req_acc_o), 0);
    lps_i = 1'b1;
    ticks(MIN_OFF + 30);
    chk(ready_o == 1'b1, "R5 ready after rewake", int'(ready_o), 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule